// File: doc/BRIEF.md
# PWM Output Action Qualifier with Software Override

This block turns time-base events into two pulse-width-modulated output levels, channel A and channel B. Each clock it may see any mix of four event strobes from an external counter: counter at zero, counter at period, compare-A match while counting up and compare-B match while counting up. Each channel owns a 16-bit action word that assigns one of four actions to each event: leave the level alone, drive it low, drive it high or invert it. The usual setting drives a channel high on the zero and period events and low on its compare match. This gives a duty cycle that follows the compare value.

A software override word can pin either channel low or high regardless of events. A written override value is held in a shadow. It only becomes the active override at a selectable reload point: a zero event, a period event, either of the two, or simply the next clock. This lets software stop or release an output on a cycle boundary without a glitch. Configuration arrives through a simple write port (enable, 2-bit address, data word).

Each channel is a two-state machine, `LVL_LOW` and `LVL_HIGH`. Its transitions are: hold, go low, go high and toggle. Forced-low and forced-high transitions take precedence over all of them. Each channel's override is a three-state machine, `FRC_OFF`, `FRC_LOW` and `FRC_HIGH`. Its single transition, load-from-shadow, fires only on a reload hit. The reload point is chosen among `RLD_ZERO`, `RLD_PERIOD`, `RLD_EITHER` and `RLD_NOW`.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, both active overrides are off and every configuration field is zero, so events alone leave both outputs low.
- R2: An event's 2-bit action code means 00 hold, 01 drive low, 10 drive high and 11 invert the current level. The output shows the result on the clock edge that samples the event.
- R3: Write address 0 selects the action word of channel A and address 1 selects the action word of channel B. In an action word the zero event uses bits [1:0], the period event bits [3:2], compare-A-up bits [5:4] and compare-B-up bits [9:8]. Bits [7:6] and [15:10] have no effect.
- R4: When several events arrive in one clock, only the one of highest priority acts: compare-B-up first, then compare-A-up, then period, then zero. Its code applies even when that code is 00 (hold).
- R5: Write address 2 is the override word. Bits [1:0] hold the code for channel A and bits [3:2] the code for channel B. Code 01 means force low, 10 means force high, and 00 or 11 means no force.
- R6: While a channel's active override is low or high, its output goes to and stays at that level whatever events occur.
- R7: Override word bits [7:6] pick the reload point, and they take effect on the write itself. 00 means a zero event, 01 a period event, 10 either of the two, and 11 every clock. On a reload hit the active override copies the shadow code. The output follows one clock later. Any other event leaves the active override unchanged.
- R8: A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_zero | input | 1 | Counter reached zero this clock |
| evt_period | input | 1 | Counter reached period this clock |
| evt_cmpa_up | input | 1 | Compare-A match while counting up |
| evt_cmpb_up | input | 1 | Compare-B match while counting up |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 2 | Configuration word select |
| cfg_wr_data | input | DATA_W | Configuration write data |
| pwm_a | output | 1 | Channel A output level |
| pwm_b | output | 1 | Channel B output level |

## Verification
The bench sweeps every action code against every single event, starting from both levels. The two channels get complementary codes, so field placement and the meaning of each code are tested separately for each channel. All sixteen event combinations are then applied against action words with a distinct code per event, from both start levels. This separates the priority order from a plain OR of the actions. All sixteen pairs of override codes are tried against invert-on-every-event words, which shows whether the override wins and whether 00 and 11 both release the channel. Each reload point is tested with events that must not load the shadow before one that must. This pins down the exact clock on which the override lands.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int unsigned NUM_OUT   = 2;
    localparam int unsigned CODE_W    = 2;

    localparam int unsigned FLD_ZERO_LSB = 0;
    localparam int unsigned FLD_PRD_LSB  = 2;
    localparam int unsigned FLD_CMPA_LSB = 4;
    localparam int unsigned FLD_CMPB_LSB = 8;
    localparam int unsigned FLD_RLD_LSB  = 6;

    localparam logic [1:0] ADDR_ACT_A = 2'd0;
    localparam logic [1:0] ADDR_ACT_B = 2'd1;
    localparam logic [1:0] ADDR_FRC   = 2'd2;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic cmpb_up;
        logic cmpa_up;
        logic period;
        logic zero;
    } evt_t;

endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [NUM_OUT-1:0][DATA_W-1:0]      act_word,
    output logic [NUM_OUT-1:0][CODE_W-1:0]      frc_shadow,
    output rld_e                                rld_mode
);

    localparam logic [ADDR_W-1:0] A_FRC = ADDR_W'(ADDR_FRC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_word   <= '0;
            frc_shadow <= '0;
            rld_mode   <= RLD_ZERO;
        end else if (wr_en) begin
            for (int o = 0; o < NUM_OUT; o++) begin
                if (wr_addr == ADDR_W'(o)) begin
                    act_word[o] <= wr_data;
                end
            end
            if (wr_addr == A_FRC) begin
                for (int o = 0; o < NUM_OUT; o++) begin
                    frc_shadow[o] <= wr_data[CODE_W*o +: CODE_W];
                end
                rld_mode <= rld_e'(wr_data[FLD_RLD_LSB +: CODE_W]);
            end
        end
    end

endmodule

// File: rtl/pwm_aq_reload.sv
module pwm_aq_reload
    import pwm_aq_pkg::*;
(
    input  rld_e  rld_mode,
    input  evt_t  evt,
    output logic  reload_hit
);

    always_comb begin
        unique case (rld_mode)
            RLD_ZERO:   reload_hit = evt.zero;
            RLD_PERIOD: reload_hit = evt.period;
            RLD_EITHER: reload_hit = evt.zero | evt.period;
            RLD_NOW:    reload_hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
    import pwm_aq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_hit,
    input  logic [CODE_W-1:0] shadow_code,
    output frc_e              frc_state
);

    frc_e state_q;
    frc_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FRC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (reload_hit) begin
            unique case (shadow_code)
                2'b01:   state_d = FRC_LOW;
                2'b10:   state_d = FRC_HIGH;
                default: state_d = FRC_OFF;
            endcase
        end
    end

    always_comb begin
        frc_state = state_q;
    end

    AST_FRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_hit |=> $stable(state_q)); // R7
    AST_FRC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_hit && (shadow_code == 2'b00 || shadow_code == 2'b11)) |=> (state_q == FRC_OFF)); // R5

endmodule

// File: rtl/pwm_aq_channel.sv
module pwm_aq_channel
    import pwm_aq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              evt,
    input  logic [DATA_W-1:0] act_cfg,
    input  frc_e              frc_state,
    output logic              pwm_out
);

    lvl_e lvl_q;
    lvl_e lvl_d;
    act_e act_sel;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{act_cfg[DATA_W-1:FLD_CMPB_LSB+CODE_W],
                               act_cfg[FLD_RLD_LSB +: CODE_W]};

    // one event acts per clock: compare-B-up, compare-A-up, period, zero
    always_comb begin
        if (evt.cmpb_up) begin
            act_sel = act_e'(act_cfg[FLD_CMPB_LSB +: CODE_W]);
        end else if (evt.cmpa_up) begin
            act_sel = act_e'(act_cfg[FLD_CMPA_LSB +: CODE_W]);
        end else if (evt.period) begin
            act_sel = act_e'(act_cfg[FLD_PRD_LSB +: CODE_W]);
        end else if (evt.zero) begin
            act_sel = act_e'(act_cfg[FLD_ZERO_LSB +: CODE_W]);
        end else begin
            act_sel = ACT_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= LVL_LOW;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        unique case (frc_state)
            FRC_LOW:  lvl_d = LVL_LOW;
            FRC_HIGH: lvl_d = LVL_HIGH;
            default: begin
                unique case (act_sel)
                    ACT_NONE:   lvl_d = lvl_q;
                    ACT_LOW:    lvl_d = LVL_LOW;
                    ACT_HIGH:   lvl_d = LVL_HIGH;
                    ACT_TOGGLE: lvl_d = (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
                endcase
            end
        endcase
    end

    always_comb begin
        pwm_out = (lvl_q == LVL_HIGH);
    end

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_state == FRC_LOW) |=> !pwm_out); // R6
    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_state == FRC_HIGH) |=> pwm_out); // R6
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_state == FRC_OFF && evt == '0) |=> $stable(pwm_out)); // R2
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_state == FRC_OFF && act_sel == ACT_TOGGLE) |=> (pwm_out != $past(pwm_out))); // R2
    AST_CMPB_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_state == FRC_OFF && evt.cmpb_up && act_cfg[FLD_CMPB_LSB +: CODE_W] == 2'b10) |=> pwm_out); // R4

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwm_aq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_zero,
    input  logic              evt_period,
    input  logic              evt_cmpa_up,
    input  logic              evt_cmpb_up,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_addr,
    input  logic [DATA_W-1:0] cfg_wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int unsigned ADDR_W = 2;

    evt_t                              evt;
    logic [NUM_OUT-1:0][DATA_W-1:0]    act_word;
    logic [NUM_OUT-1:0][CODE_W-1:0]    frc_shadow;
    rld_e                              rld_mode;
    logic                              reload_hit;
    frc_e                              frc_state [NUM_OUT];
    logic [NUM_OUT-1:0]                pwm_vec;

    assign evt.zero    = evt_zero;
    assign evt.period  = evt_period;
    assign evt.cmpa_up = evt_cmpa_up;
    assign evt.cmpb_up = evt_cmpb_up;

    pwm_aq_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .act_word   (act_word),
        .frc_shadow (frc_shadow),
        .rld_mode   (rld_mode)
    );

    pwm_aq_reload u_reload (
        .rld_mode   (rld_mode),
        .evt        (evt),
        .reload_hit (reload_hit)
    );

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        pwm_aq_force u_force (
            .clk         (clk),
            .rst_n       (rst_n),
            .reload_hit  (reload_hit),
            .shadow_code (frc_shadow[o]),
            .frc_state   (frc_state[o])
        );

        pwm_aq_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt),
            .act_cfg   (act_word[o]),
            .frc_state (frc_state[o]),
            .pwm_out   (pwm_vec[o])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

    AST_ADDR3_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_addr == 2'd3) |=> ($stable(act_word) && $stable(frc_shadow) && $stable(rld_mode))); // R8

endmodule

// File: tb/pwm_action_qual_tb.sv
`timescale 1ns/1ps
module pwm_action_qual_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_zero, evt_period, evt_cmpa_up, evt_cmpb_up;
    logic        cfg_wr_en;
    logic [1:0]  cfg_wr_addr;
    logic [15:0] cfg_wr_data;
    logic        pwm_a, pwm_b;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwm_action_qual #(.DATA_W(16)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_zero    (evt_zero),
        .evt_period  (evt_period),
        .evt_cmpa_up (evt_cmpa_up),
        .evt_cmpb_up (evt_cmpb_up),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .pwm_a       (pwm_a),
        .pwm_b       (pwm_b)
    );

    // event mask: bit0 zero, bit1 period, bit2 compare-A-up, bit3 compare-B-up
    task automatic tick(input logic [3:0] m);
        {evt_cmpb_up, evt_cmpa_up, evt_period, evt_zero} = m;
        @(posedge clk);
        @(negedge clk);
        {evt_cmpb_up, evt_cmpa_up, evt_period, evt_zero} = 4'h0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = a;
        cfg_wr_data = d;
        tick(4'h0);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic check(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got=%0b expected=%0b", what, got, exp);
        end
    endtask

    function automatic logic apply(input logic [1:0] c, input logic l);
        case (c)
            2'b00:   return l;
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            default: return ~l;
        endcase
    endfunction

    function automatic int lsb_of(input int e);
        return (e == 3) ? 8 : 2 * e;
    endfunction

    task automatic set_level(input logic la, input logic lb);
        wr(2'd0, la ? 16'h0002 : 16'h0001);
        wr(2'd1, lb ? 16'h0002 : 16'h0001);
        tick(4'h1);
    endtask

    task automatic clear_force();
        wr(2'd2, 16'h00C0);
        tick(4'h0);
    endtask

    task automatic rld_case(input logic [1:0] mode, input logic [3:0] miss, input logic [3:0] hit);
        clear_force();
        set_level(1'b1, 1'b0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd2, {8'h00, mode, 6'b00_10_01});
        if (miss != 4'h0) begin
            tick(miss);
            tick(4'h0);
            check(pwm_a, 1'b1, $sformatf("R7 mode %0d not loaded by mask %h (A)", mode, miss));
            check(pwm_b, 1'b0, $sformatf("R7 mode %0d not loaded by mask %h (B)", mode, miss));
        end
        tick(hit);
        check(pwm_a, 1'b1, $sformatf("R7 mode %0d output lags reload (A)", mode));
        tick(4'h0);
        check(pwm_a, 1'b0, $sformatf("R7 mode %0d forced low after reload (A)", mode));
        check(pwm_b, 1'b1, $sformatf("R7 mode %0d forced high after reload (B)", mode));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {evt_cmpb_up, evt_cmpa_up, evt_period, evt_zero} = 4'h0;
        cfg_wr_en = 1'b0; cfg_wr_addr = 2'd0; cfg_wr_data = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, events alone keep both low
        check(pwm_a, 1'b0, "R1 reset level A");
        check(pwm_b, 1'b0, "R1 reset level B");
        tick(4'hF);
        check(pwm_a, 1'b0, "R1 zero config ignores events A");
        check(pwm_b, 1'b0, "R1 zero config ignores events B");

        // R2/R3: every code on every single event, both start levels
        for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 4; e++) begin
                for (int l = 0; l < 2; l++) begin
                    set_level(l[0], ~l[0]);
                    wr(2'd0, 16'(c) << lsb_of(e));
                    wr(2'd1, 16'(3 - c) << lsb_of(e));
                    tick(4'(1 << e));
                    check(pwm_a, apply(2'(c), l[0]), $sformatf("R2 R3 A code %0d event %0d", c, e));
                    check(pwm_b, apply(2'(3 - c), ~l[0]), $sformatf("R2 R3 B code %0d event %0d", 3 - c, e));
                end
            end
        end

        // R4: all event combinations, highest priority alone acts
        for (int l = 0; l < 2; l++) begin
            for (int m = 0; m < 16; m++) begin
                logic [15:0] ca, cb;
                logic ea, eb;
                int top;
                ca = 16'h0036;
                cb = 16'h0309;
                set_level(l[0], ~l[0]);
                wr(2'd0, ca);
                wr(2'd1, cb);
                tick(4'(m));
                top = -1;
                for (int e = 0; e < 4; e++) if (m[e]) top = e;
                ea = (top < 0) ? l[0]  : apply(2'(ca >> lsb_of(top)), l[0]);
                eb = (top < 0) ? ~l[0] : apply(2'(cb >> lsb_of(top)), ~l[0]);
                check(pwm_a, ea, $sformatf("R4 A mask %h", m));
                check(pwm_b, eb, $sformatf("R4 B mask %h", m));
            end
        end

        // R3: spare bits of an action word do nothing
        set_level(1'b1, 1'b0);
        wr(2'd0, 16'hFCC0);
        wr(2'd1, 16'hFCC0);
        tick(4'hF);
        check(pwm_a, 1'b1, "R3 spare bits inert A");
        check(pwm_b, 1'b0, "R3 spare bits inert B");

        // R8: address 3 writes are dropped
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd3, 16'hFFFF);
        tick(4'hF);
        check(pwm_a, 1'b1, "R8 address 3 inert A");
        check(pwm_b, 1'b0, "R8 address 3 inert B");

        // R5/R6: every override pair against invert-on-all-events words
        for (int fa = 0; fa < 4; fa++) begin
            for (int fb = 0; fb < 4; fb++) begin
                for (int l = 0; l < 2; l++) begin
                    logic ea, eb;
                    clear_force();
                    set_level(l[0], ~l[0]);
                    wr(2'd0, 16'h033F);
                    wr(2'd1, 16'h033F);
                    wr(2'd2, 16'h00C0 | 16'(fb << 2) | 16'(fa));
                    tick(4'h1);
                    check(pwm_a, ~l[0], $sformatf("R7 A override not yet visible fa=%0d", fa));
                    tick(4'h1);
                    ea = (fa == 1) ? 1'b0 : (fa == 2) ? 1'b1 : l[0];
                    eb = (fb == 1) ? 1'b0 : (fb == 2) ? 1'b1 : ~l[0];
                    check(pwm_a, ea, $sformatf("R5 R6 A override code %0d", fa));
                    check(pwm_b, eb, $sformatf("R5 R6 B override code %0d", fb));
                end
            end
        end

        // R7: reload points
        rld_case(2'd0, 4'hE, 4'h1);
        rld_case(2'd1, 4'hD, 4'h2);
        rld_case(2'd2, 4'hC, 4'h1);
        rld_case(2'd2, 4'hC, 4'h2);
        rld_case(2'd3, 4'h0, 4'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule